// File: doc/BRIEF.md
# Stripmined Vector Sum Reduction Engine

This block adds up a stream of N integer values that arrives in chunks of LANES values, one chunk per handshake. It keeps a bank of LANES partial sums. Each accepted chunk is added lane by lane into that bank, so a long input is handled in strips of LANES values. When the last strip is in, the bank is folded in half again and again. On each fold the upper half of the live entries is added into the lower half, until a single entry holds the total.

A job starts with a `start` pulse that carries the element count `n_total`. The block then asks for ceil(n_total/LANES) chunks through a valid/ready handshake. The final chunk may be partial. After log2(LANES) fold steps, `done` pulses for one cycle and `sum_out` carries the total, wrapped modulo 2^DW. The block takes no new job until the current one has completed.

Top module: `vsum_reduce_engine`

## Requirements
- R1: After reset, `done` and `in_ready` are 0, and the block is idle, waiting for `start`.
- R2: A `start` seen while idle clears every partial sum to zero. The total of a job does not depend on earlier jobs or on data offered while idle.
- R3: `in_ready` is 1 only while chunks are being collected. A chunk is taken on a clock edge where `in_valid` and `in_ready` are both 1. Exactly ceil(n_total/LANES) chunks are taken per job.
- R4: Lane j of `in_data` (bits j*DW to j*DW+DW-1) carries element c*LANES+j of chunk c. In a partial last chunk, lanes whose element index is at or beyond `n_total` count as zero, whatever their value.
- R5: Every fold step halves the live width and adds the entries from half to 2*half-1 into entries 0 to half-1. `done` rises exactly log2(LANES) clock edges (3 for LANES=8) after the edge that took the last chunk. For `n_total`=0, it rises 3 edges after the start edge.
- R6: `done` is high for exactly one cycle per job. While `done` is high, `sum_out` equals the sum of the N elements modulo 2^DW.
- R7: A job with `n_total`=0 takes no chunk and returns 0.
- R8: A `start` raised while a job is in progress is ignored. The current job's count and result are unchanged, and no extra result appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a job; honoured only when idle |
| n_total | input | LEN_W | Number of elements in the job, sampled with an accepted start |
| in_valid | input | 1 | A chunk is present on `in_data` |
| in_ready | output | 1 | The block takes a chunk on this edge if `in_valid` is high |
| in_data | input | LANES*DW | Chunk; lane j sits at bits j*DW upward |
| done | output | 1 | One-cycle pulse marking a valid result |
| sum_out | output | DW | Total, valid while `done` is high |

## Verification
Several input patterns are used. A single full chunk shows that the lane bank folds correctly. Counts of 1, 13 and 37 leave a partial last chunk, and its dead lanes are filled with a poison pattern to catch any lane that is not masked. A count of zero takes the path that skips collection. A long run of all-ones values shows wraparound of the total. Gaps in `in_valid`, data offered while idle, and a stray `start` during collection show that only handshaken chunks in a running job reach the sum. Back-to-back jobs show that each job starts from a cleared bank.

// File: rtl/vsum_pkg.sv
`timescale 1ns/1ps
package vsum_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ACCUM = 2'd1,
    ST_FOLD  = 2'd2,
    ST_DONE  = 2'd3
  } vsum_state_e;

  // A lane is live when its position in the chunk is below the elements still owed.
  function automatic logic lane_live(int unsigned lane, int unsigned remaining);
    return lane < remaining;
  endfunction

  // Elements consumed by one chunk: the lane count, or fewer for the tail.
  function automatic int unsigned chunk_take(int unsigned remaining, int unsigned lanes);
    return (remaining < lanes) ? remaining : lanes;
  endfunction

  // Modular lane addition; the width of the operands defines the wrap.
  function automatic logic [31:0] wrap_add32(logic [31:0] a, logic [31:0] b);
    return a + b;
  endfunction

endpackage

// File: rtl/vsum_ctrl.sv
`timescale 1ns/1ps
module vsum_ctrl
  import vsum_pkg::*;
#(
  parameter int LANES = 8,
  parameter int LEN_W = 16,
  localparam int HW   = (LANES > 2) ? $clog2(LANES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] n_total,
  input  logic             in_valid,
  output logic             in_ready,
  output logic             accept,
  output logic             clr,
  output logic [LANES-1:0] keep,
  output logic             fold_en,
  output logic [HW-1:0]    fold_half,
  output logic             done
);

  vsum_state_e      state_q;
  logic [LEN_W-1:0] rem_q;
  logic [HW-1:0]    half_q;
  logic             start_ok;
  logic             last_chunk;

  assign in_ready   = (state_q == ST_ACCUM);
  assign accept     = in_valid && in_ready;
  assign start_ok   = start && (state_q == ST_IDLE);
  assign clr        = start_ok;
  assign fold_en    = (state_q == ST_FOLD);
  assign fold_half  = half_q;
  assign done       = (state_q == ST_DONE);
  assign last_chunk = (rem_q <= LEN_W'(LANES));

  for (genvar g = 0; g < LANES; g++) begin : g_keep
    assign keep[g] = lane_live(g, 32'(rem_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rem_q   <= '0;
      half_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start_ok) begin
            rem_q   <= n_total;
            half_q  <= HW'(LANES / 2);
            state_q <= (n_total == '0) ? ST_FOLD : ST_ACCUM;
          end
        end
        ST_ACCUM: begin
          if (accept) begin
            rem_q <= rem_q - LEN_W'(chunk_take(32'(rem_q), LANES));
            if (last_chunk) state_q <= ST_FOLD;
          end
        end
        ST_FOLD: begin
          if (half_q == HW'(1)) state_q <= ST_DONE;
          else                  half_q  <= half_q >> 1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R6: the result flag never lasts two cycles
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5: each fold step halves the live width
  a_r5_half_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    (fold_en && fold_half != HW'(1)) |=> (fold_half == ($past(fold_half) >> 1)));

  // R3: taking the last chunk moves straight on to folding
  a_r3_last_then_fold: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && last_chunk) |=> fold_en);

  // R8: a start during collection leaves the owed count alone
  a_r8_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (start && in_ready && !accept) |=> (rem_q == $past(rem_q)));

endmodule

// File: rtl/vsum_lane_bank.sv
`timescale 1ns/1ps
module vsum_lane_bank
  import vsum_pkg::*;
#(
  parameter int LANES = 8,
  parameter int DW    = 32,
  localparam int HW   = (LANES > 2) ? $clog2(LANES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               acc_en,
  input  logic [LANES-1:0]   keep,
  input  logic [LANES*DW-1:0] chunk,
  input  logic               fold_en,
  input  logic [HW-1:0]      fold_half,
  output logic [DW-1:0]      total
);

  logic [DW-1:0] part_q [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [DW-1:0] elem;
    logic [DW-1:0] addend;
    logic [DW-1:0] partner;
    logic          fold_live;

    assign elem      = chunk[g*DW +: DW];
    assign addend    = keep[g] ? elem : '0;
    assign fold_live = fold_en && (g < 32'(fold_half));

    always_comb begin
      partner = '0;
      for (int k = 0; k < LANES; k++) begin
        if (k == g + 32'(fold_half)) partner = part_q[k];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         part_q[g] <= '0;
      else if (clr)       part_q[g] <= '0;
      else if (acc_en)    part_q[g] <= DW'(wrap_add32(32'(part_q[g]), 32'(addend)));
      else if (fold_live) part_q[g] <= DW'(wrap_add32(32'(part_q[g]), 32'(partner)));
    end

    // R2: a cleared lane starts the job from zero
    a_r2_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (part_q[g] == '0));

    // R4: a dead lane of a partial chunk leaves its partial sum alone
    a_r4_dead_lane_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_en && !keep[g]) |=> (part_q[g] == $past(part_q[g])));
  end

  assign total = part_q[0];

endmodule

// File: rtl/vsum_reduce_engine.sv
`timescale 1ns/1ps
module vsum_reduce_engine #(
  parameter int LANES = 8,
  parameter int DW    = 32,
  parameter int LEN_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [LEN_W-1:0]    n_total,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [LANES*DW-1:0] in_data,
  output logic                done,
  output logic [DW-1:0]       sum_out
);

  localparam int HW = (LANES > 2) ? $clog2(LANES) : 1;

  logic             accept;
  logic             clr;
  logic [LANES-1:0] keep;
  logic             fold_en;
  logic [HW-1:0]    fold_half;

  vsum_ctrl #(.LANES(LANES), .LEN_W(LEN_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .n_total  (n_total),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .accept   (accept),
    .clr      (clr),
    .keep     (keep),
    .fold_en  (fold_en),
    .fold_half(fold_half),
    .done     (done)
  );

  vsum_lane_bank #(.LANES(LANES), .DW(DW)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .acc_en   (accept),
    .keep     (keep),
    .chunk    (in_data),
    .fold_en  (fold_en),
    .fold_half(fold_half),
    .total    (sum_out)
  );

endmodule

// File: tb/vsum_reduce_engine_tb.sv
`timescale 1ns/1ps
module vsum_reduce_engine_tb;
  localparam int LANES = 8;
  localparam int DW    = 32;
  localparam int LEN_W = 16;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                start = 1'b0;
  logic [LEN_W-1:0]    n_total = '0;
  logic                in_valid = 1'b0;
  logic                in_ready;
  logic [LANES*DW-1:0] in_data = '0;
  logic                done;
  logic [DW-1:0]       sum_out;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  bit prev_done = 1'b0;
  logic [31:0] exp_q[$];

  always #2.5 clk = ~clk;

  vsum_reduce_engine #(.LANES(LANES), .DW(DW), .LEN_W(LEN_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .n_total(n_total),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .done(done), .sum_out(sum_out)
  );

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // Element generator; seed 99 gives all-ones to force wraparound.
  function automatic logic [31:0] elem_val(int seed, int idx);
    logic [31:0] s, i;
    s = 32'(seed);
    i = 32'(idx);
    if (seed == 99) return 32'hFFFF_FFFF;
    return (s * 32'h9E37_79B9) ^ (i * i * 32'd7 + i + 32'd3);
  endfunction

  // Monitor: pops the scoreboard on each result pulse (R6).
  always @(negedge clk) begin
    if (rst_n) begin
      if (done) begin
        chk(!prev_done, "R6", "done lasted more than one cycle", 32'(prev_done), 32'd0);
        if (exp_q.size() == 0) chk(1'b0, "R8", "unexpected extra result", sum_out, 32'd0);
        else begin
          logic [31:0] e;
          e = exp_q.pop_front();
          chk(sum_out == e, "R6", "sum at done", sum_out, e);
        end
      end
      prev_done = done;
    end
  end

  // Driver: pushes the expected total, then feeds the job.
  task automatic run_job(int n, int seed, int gap, bit poke_start);
    logic [31:0] sum;
    int nch, lat;
    sum = '0;
    for (int i = 0; i < n; i++) sum = sum + elem_val(seed, i);
    exp_q.push_back(sum);
    nch = (n + LANES - 1) / LANES;
    start = 1'b1;
    n_total = LEN_W'(n);
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c < nch; c++) begin
      if (gap > 0 && (c % 2) == 1) begin
        in_valid = 1'b0;
        repeat (gap) @(negedge clk);
        chk(in_ready == 1'b1, "R3", "ready held during gap", 32'(in_ready), 32'd1);
      end
      for (int j = 0; j < LANES; j++) begin
        int idx;
        idx = c * LANES + j;
        in_data[j*DW +: DW] = (idx < n) ? elem_val(seed, idx) : 32'hDEAD_BEEF; // R4 poison
      end
      in_valid = 1'b1;
      if (poke_start && c == 0) begin
        start = 1'b1;                       // R8 stray start during collection
        n_total = LEN_W'(3);
      end
      chk(in_ready == 1'b1, "R3", "ready while collecting", 32'(in_ready), 32'd1);
      @(negedge clk);
      start = 1'b0;
    end
    in_valid = 1'b0;
    lat = 0;
    while (!done && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    chk(lat == 3, "R5", "fold latency in edges", 32'(lat), 32'd3);
    chk(in_ready == 1'b0, "R3", "ready low while folding/done", 32'(in_ready), 32'd0);
    @(negedge clk);
    chk(done == 1'b0 && in_ready == 1'b0, "R1", "idle after job", {30'd0, done, in_ready}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "R6", "watchdog expired", 32'd0, 32'd1);
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R1", "done in reset", 32'(done), 32'd0);
    chk(in_ready == 1'b0, "R1", "ready in reset", 32'(in_ready), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done == 1'b0 && in_ready == 1'b0, "R1", "idle after reset", {30'd0, done, in_ready}, 32'd0);

    run_job(8, 1, 0, 1'b0);   // one full chunk
    run_job(1, 2, 0, 1'b0);   // R4 single element, seven dead lanes
    run_job(13, 3, 0, 1'b0);  // R4 partial tail

    // R2: chunks offered while idle must not be absorbed
    in_valid = 1'b1;
    for (int j = 0; j < LANES; j++) in_data[j*DW +: DW] = 32'h1234_5678;
    repeat (3) begin
      @(negedge clk);
      chk(in_ready == 1'b0, "R2", "idle refuses data", 32'(in_ready), 32'd0);
    end
    in_valid = 1'b0;

    run_job(0, 4, 0, 1'b0);   // R7 empty job returns zero
    run_job(64, 99, 0, 1'b0); // R6 wraparound: expect FFFFFFC0
    run_job(37, 5, 2, 1'b0);  // R3 gaps in valid
    run_job(21, 6, 0, 1'b1);  // R8 stray start
    run_job(100, 7, 1, 1'b0); // R2 back-to-back, longer job

    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R6", "all results produced", 32'(exp_q.size()), 32'd0);
    report();
  end

endmodule